// File: doc/BRIEF.md
# Maskable Interrupt Flag Controller

This block gathers seven single-cycle hardware event pulses into sticky flag bits. It drives one active-high interrupt line to a byte-wide microcontroller. Software sees two 8-bit registers on the register bus, a mask and a flag register, at adjacent addresses. A flag whose mask bit is clear is still recorded, so software can poll for it, but it does not raise the interrupt line. Software clears a flag by writing a zero to its position. A one leaves the flag as it is, so software can never create a flag.

The interrupt line comes out of reset asserted. A release latch, set by reset, holds it high until software writes exactly 0x00 to the flag register. After that the line is a registered OR over every flag that is enabled in the mask.

Top module: `irq_flag_ctrl`

## Requirements
- R1: While and after reset, the mask register (address 0xF0FB) reads 0x00, the flag register (address 0xF0FC) reads 0x00 and `irq` is 1.
- R2: A write to 0xF0FB stores all 8 data bits in the mask, and a read of 0xF0FB returns them. The mask changes only on such a write.
- R3: A write to 0xF0FC clears every flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged. A write can never set a flag.
- R4: A one-cycle pulse on `evt_pulse[i]` sets flag bit i at the next clock edge, and the flag stays set until a write clears it. Bit map: 0 frame stored, 1 stream last, 2 full 2352-byte frame, 3 header, 4 error correction done, 5 front-end receive, 6 front-end transmit.
- R5: Bit 7 of the flag register always reads 0, even after a write of 1 to it.
- R6: If an event pulse and a clearing write hit the same flag bit in the same cycle, the flag ends up set.
- R7: An event whose mask bit is 0 sets its flag but never raises `irq` once the release latch is clear.
- R8: Once the release latch is clear, `irq` equals the OR of (flag AND mask) as it was one clock earlier. After an event pulse, `irq` rises two clock edges later.
- R9: The release latch is cleared only by a write of 0x00 to 0xF0FC. Non-zero flag writes, writes to the mask and writes to other addresses leave `irq` held at 1.
- R10: Reads do not change any state. A read of any other address returns 0x00, and writes to other addresses change nothing.
- R11: When the last enabled flag is cleared by a write, `irq` falls one clock edge after the flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| rd_en | input | 1 | Read strobe, qualifies `rdata` |
| addr | input | 16 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational, 0 when not reading a register) |
| evt_pulse | input | 7 | One-cycle event pulses, one per flag bit |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit data byte and seven events. This leaves one spare data bit, so the always-zero flag bit 7 and a write of 1 to it can be reached. With these defaults every flag position can be pulsed one at a time, and a single mask bit can be aimed at one flag while its neighbours stay masked. The exact 0x00 release value can also be compared against near misses on the flag address and on adjacent addresses.

// File: rtl/irqfc_pkg.sv
package irqfc_pkg;

  // Which register a read selects
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_FLAG = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/irqfc_regdec.sv
module irqfc_regdec
  import irqfc_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 16'hF0FB,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'hF0FC
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_mask,
  output logic              wr_flag,
  output reg_sel_e          rd_sel
);

  logic hit_mask;
  logic hit_flag;

  assign hit_mask = (addr == MASK_ADDR);
  assign hit_flag = (addr == FLAG_ADDR);

  assign wr_mask = wr_en & hit_mask;
  assign wr_flag = wr_en & hit_flag;

  always_comb begin
    rd_sel = SEL_NONE;
    if (rd_en) begin
      if (hit_mask)      rd_sel = SEL_MASK;
      else if (hit_flag) rd_sel = SEL_FLAG;
    end
  end

endmodule

// File: rtl/irqfc_flagbank.sv
module irqfc_flagbank #(
  parameter int N_EVT  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  evt,
  input  logic              wr_flag,
  input  logic [DATA_W-1:0] wdata,
  output logic [N_EVT-1:0]  flags
);

  for (genvar gi = 0; gi < N_EVT; gi++) begin : g_bit
    logic clr_w;   // write of 0 aimed at this bit
    logic flag_q;

    assign clr_w = wr_flag & ~wdata[gi];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (evt[gi])  flag_q <= 1'b1;   // event beats clear
      else if (clr_w)    flag_q <= 1'b0;
    end

    assign flags[gi] = flag_q;

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt[gi] |=> flag_q);                                        // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !(wr_flag && !wdata[gi])) |=> flag_q);           // R4
    AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && !evt[gi]) |=> !flag_q);                         // R3
  end

endmodule

// File: rtl/irqfc_gate.sv
module irqfc_gate #(
  parameter int N_EVT  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  flags,
  input  logic [N_EVT-1:0]  mask,
  input  logic              wr_flag,
  input  logic [DATA_W-1:0] wdata,
  output logic              irq
);

  function automatic logic any_enabled(input logic [N_EVT-1:0] f,
                                       input logic [N_EVT-1:0] m);
    return |(f & m);
  endfunction

  function automatic logic is_release(input logic [DATA_W-1:0] d);
    return (d == '0);
  endfunction

  logic release_w;  // write of 0x00 to the flag register
  logic latch_q;    // reset-held interrupt latch
  logic pend_q;     // registered OR of enabled flags
  logic enabled_w;

  assign release_w = wr_flag & is_release(wdata);
  assign enabled_w = any_enabled(flags, mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         latch_q <= 1'b1;
    else if (release_w) latch_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= enabled_w;
  end

  assign irq = latch_q | pend_q;

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !release_w) |=> latch_q);                         // R9
  AST_LATCH_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_q |=> !latch_q);                                       // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_q && !release_w && !enabled_w) |=> !irq);             // R8
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    enabled_w |=> irq);                                           // R8

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irqfc_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter int                N_EVT     = 7,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 16'hF0FB,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'hF0FC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [N_EVT-1:0]  evt_pulse,
  output logic              irq
);

  localparam int SPARE_W = DATA_W - N_EVT;

  logic              wr_mask;
  logic              wr_flag;
  reg_sel_e          rd_sel;
  logic [DATA_W-1:0] mask_q;
  logic [N_EVT-1:0]  flags;
  logic [DATA_W-1:0] flag_rd;

  irqfc_regdec #(
    .ADDR_W(ADDR_W), .MASK_ADDR(MASK_ADDR), .FLAG_ADDR(FLAG_ADDR)
  ) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_mask(wr_mask), .wr_flag(wr_flag), .rd_sel(rd_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= wdata;
  end

  irqfc_flagbank #(.N_EVT(N_EVT), .DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt_pulse),
    .wr_flag(wr_flag), .wdata(wdata), .flags(flags)
  );

  irqfc_gate #(.N_EVT(N_EVT), .DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .flags(flags), .mask(mask_q[N_EVT-1:0]),
    .wr_flag(wr_flag), .wdata(wdata), .irq(irq)
  );

  if (SPARE_W > 0) begin : g_spare
    assign flag_rd = {{SPARE_W{1'b0}}, flags};

    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == FLAG_ADDR) |-> (rdata[DATA_W-1:N_EVT] == '0)); // R5
  end else begin : g_full
    assign flag_rd = flags;
  end

  always_comb begin
    unique case (rd_sel)
      SEL_MASK: rdata = mask_q;
      SEL_FLAG: rdata = flag_rd;
      default:  rdata = '0;
    endcase
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == MASK_ADDR) |=> $stable(mask_q));           // R2
  AST_FOREIGN_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr != MASK_ADDR && addr != FLAG_ADDR) |-> (rdata == '0)); // R10

endmodule

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;

  localparam int   CLK_PERIOD = 10;
  localparam logic [15:0] A_MASK = 16'hF0FB;
  localparam logic [15:0] A_FLAG = 16'hF0FC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [6:0]  evt_pulse = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_flag_ctrl u_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_pulse(evt_pulse), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] v);
    @(negedge clk);
    evt_pulse = v;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    @(negedge clk);
    check("R1 irq during reset", {7'd0, irq}, 8'h01);
    do_reset();
    bus_rd(A_MASK, d); check("R1 mask after reset", d, 8'h00);
    bus_rd(A_FLAG, d); check("R1 flag after reset", d, 8'h00);
    check("R1 irq after reset", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_release_latch();
    bus_wr(A_MASK, 8'h00);
    @(negedge clk); check("R9 mask write keeps latch", {7'd0, irq}, 8'h01);
    bus_wr(16'hF0FD, 8'h00);
    @(negedge clk); check("R9 foreign write keeps latch", {7'd0, irq}, 8'h01);
    bus_wr(A_FLAG, 8'h80);
    @(negedge clk); check("R9 nonzero flag write keeps latch", {7'd0, irq}, 8'h01);
    bus_wr(A_FLAG, 8'h00);
    check("R9 zero write releases", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_mask_rw();
    logic [7:0] d;
    bus_wr(A_MASK, 8'hA5);
    bus_rd(A_MASK, d); check("R2 mask readback", d, 8'hA5);
    bus_wr(A_MASK, 8'h00);
    bus_rd(A_MASK, d); check("R2 mask rewrite", d, 8'h00);
  endtask

  task automatic t_sticky_masked();
    logic [7:0] d;
    logic [7:0] exp = 8'h00;
    for (int i = 0; i < 7; i++) begin
      pulse(7'(1 << i));
      exp[i] = 1'b1;
      repeat (2) @(negedge clk);
      bus_rd(A_FLAG, d); check("R4 sticky flag accumulate", d, exp);
      check("R7 masked event no irq", {7'd0, irq}, 8'h00);
    end
    bus_wr(A_FLAG, 8'hFF);
    bus_rd(A_FLAG, d); check("R3 write ones keeps flags", d, 8'h7F);
    check("R5 bit7 reads zero", {7'd0, d[7]}, 8'h00);
    bus_wr(A_FLAG, 8'h7E);
    bus_rd(A_FLAG, d); check("R3 zero clears bit0 only", d, 8'h7E);
    bus_wr(A_FLAG, 8'h00);
    bus_rd(A_FLAG, d); check("R3 clear all", d, 8'h00);
  endtask

  task automatic t_irq_timing();
    logic [7:0] d;
    bus_wr(A_MASK, 8'h10);
    pulse(7'h04);
    repeat (2) @(negedge clk);
    check("R7 masked bit2 no irq", {7'd0, irq}, 8'h00);
    pulse(7'h10);
    check("R8 irq not yet after one edge", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R8 irq two edges after event", {7'd0, irq}, 8'h01);
    bus_wr(A_FLAG, 8'hEF);
    bus_rd(A_FLAG, d); check("R11 bit4 cleared bit2 kept", d, 8'h04);
    bus_wr(A_MASK, 8'h10);  // filler cycles, mask unchanged
    check("R11 irq drops after clear", {7'd0, irq}, 8'h00);
    bus_wr(A_FLAG, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    @(negedge clk);
    evt_pulse = 7'h08; wr_en = 1'b1; addr = A_FLAG; wdata = 8'h00;
    @(negedge clk);
    evt_pulse = '0; wr_en = 1'b0;
    bus_rd(A_FLAG, d); check("R6 event beats clear", d, 8'h08);
    bus_wr(A_FLAG, 8'h00);
  endtask

  task automatic t_foreign();
    logic [7:0] d;
    bus_wr(A_MASK, 8'h3C);
    pulse(7'h21);
    bus_wr(16'hF0FA, 8'h00);
    bus_wr(16'hF0FD, 8'h00);
    bus_rd(16'hF0FD, d); check("R10 foreign read zero", d, 8'h00);
    bus_rd(A_FLAG, d);   check("R10 flags after foreign writes", d, 8'h21);
    bus_rd(A_FLAG, d);   check("R10 reread no side effect", d, 8'h21);
    bus_rd(A_MASK, d);   check("R10 mask after foreign writes", d, 8'h3C);
    check("R8 irq enabled bit5", {7'd0, irq}, 8'h01);
  endtask

  initial begin
    t_reset_state();
    t_release_latch();
    t_mask_rw();
    t_sticky_masked();
    t_irq_timing();
    t_collision();
    t_foreign();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule